// File: doc/BRIEF.md
# Split-Aware Shared Bus Arbiter

This block decides which of several bus masters owns a shared high-performance bus. Each master raises a request line. The arbiter answers with a one-hot grant vector and a binary number naming the master whose address phase is on the bus. Ownership only moves at the end of a transfer, which is the cycle in which the ready input is high. Among the masters that may compete, the lowest index wins. When no master may compete, the bus goes to a default master that only drives idle cycles.

The arbiter also watches the slave response code. A slave can answer with SPLIT when it expects the transfer to take a long time. The master that owns the address phase is then parked. It stays out of arbitration, even while it keeps requesting, so the bus is free for other masters. The slave brings a parked master back by raising that master's bit on a release vector. From then on the master competes again under the normal priority order.

Top module: `split_bus_arbiter`

## Requirements
- R1: Exactly one bit of `grant` is high in every cycle.
- R2: While `rst` is high at a clock edge, the arbiter sets `grant` to master 0 only (`0001`) and `owner_id` to 0, and clears every parked state.
- R3: At a clock edge with `ready` high, the grant moves to the lowest-index master that is requesting and is not parked.
- R4: At a clock edge with `ready` high, if no master is both requesting and unparked, master 0 receives the grant, even if master 0 is itself parked.
- R5: At a clock edge with `ready` low, `grant` and `owner_id` keep their values.
- R6: At a clock edge with `ready` high, `owner_id` takes the binary index (0 to 3) of the master that held the grant just before that edge.
- R7: `resp` is encoded as 00 OKAY, 01 ERROR, 10 RETRY and 11 SPLIT. A SPLIT seen with `ready` low parks the master numbered `owner_id`. A parked master receives no further grant while another master, or none, requests (except the default case of R4).
- R8: A SPLIT seen with `ready` high parks no master, and neither does ERROR or RETRY with `ready` low.
- R9: A high bit `split_release[i]` un-parks master i at that edge, so that master i can win arbitration at later edges.
- R10: If a SPLIT that parks master i and a high `split_release[i]` arrive in the same cycle, master i ends up parked.
- R11: A high `split_release[i]` for a master that is not parked has no effect on the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 4 | Bus request, one bit per master |
| ready | input | 1 | Transfer complete; ownership may change at this edge |
| resp | input | 2 | Slave response code (00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT) |
| split_release | input | 4 | Slave release vector; bit i lets parked master i compete again |
| grant | output | 4 | One-hot bus grant |
| owner_id | output | 2 | Index of the master in the current address phase |

## Verification
The bench uses the default values: four masters, with master 0 as the default master. With four masters, every request pattern (16 in all) can be swept under each parked set the bench creates. The sweep covers priority between unparked masters and the fallback to the default master. Split scenarios walk a master through being parked, then the grant moving to another requester, then release. They add the corner cases: SPLIT with ready high, release and SPLIT in the same cycle, and release of a master that was never parked.

// File: rtl/split_arb_pkg.sv
package split_arb_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY  = 2'b00,
        RESP_ERROR = 2'b01,
        RESP_RETRY = 2'b10,
        RESP_SPLIT = 2'b11
    } bus_resp_e;

    // A split is taken only in the first (wait) cycle of the two-cycle response
    function automatic logic split_seen(input bus_resp_e code, input logic rdy);
        return (code == RESP_SPLIT) && !rdy;
    endfunction

endpackage

// File: rtl/split_mask_ctrl.sv
module split_mask_ctrl #(
    parameter int N_MASTERS = 4,
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  split_arb_pkg::bus_resp_e resp,
    input  logic                   ready,
    input  logic [IDW-1:0]         owner_id,
    input  logic [N_MASTERS-1:0]   split_release,
    output logic [N_MASTERS-1:0]   parked
);
    import split_arb_pkg::*;

    logic split_now;
    assign split_now = split_seen(resp, ready);

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_park
        logic hit;
        assign hit = split_now && (owner_id == IDW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                parked[i] <= 1'b0;
            end else if (hit) begin
                parked[i] <= 1'b1;      // a new split outranks a release
            end else if (split_release[i]) begin
                parked[i] <= 1'b0;
            end
        end

        // R7
        park_on_split_chk: assert property (@(posedge clk) disable iff (rst)
            (resp == RESP_SPLIT && !ready && owner_id == IDW'(i)) |=> parked[i]);
        // R9
        release_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (split_release[i] && !(resp == RESP_SPLIT && !ready && owner_id == IDW'(i)))
            |=> !parked[i]);
        // R8
        no_spurious_park_chk: assert property (@(posedge clk) disable iff (rst)
            (!parked[i] && !(resp == RESP_SPLIT && !ready)) |=> !parked[i]);
    end

endmodule

// File: rtl/prio_picker.sv
module prio_picker #(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0
) (
    input  logic [N_MASTERS-1:0] req,
    input  logic [N_MASTERS-1:0] parked,
    output logic [N_MASTERS-1:0] pick
);
    logic [N_MASTERS-1:0] eligible;
    logic [N_MASTERS:0]   taken;   // taken[i]: some index below i already won
    logic [N_MASTERS-1:0] winner;

    assign eligible = req & ~parked;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_chain
        assign winner[i]  = eligible[i] && !taken[i];
        assign taken[i+1] = taken[i] || eligible[i];
    end

    always_comb begin
        if (taken[N_MASTERS]) begin
            pick = winner;
        end else begin
            pick = '0;
            pick[DEFAULT_MASTER] = 1'b1;
        end
    end

    // R1
    pick_onehot_chk: assert final ($onehot(pick));
    // R3
    pick_eligible_chk: assert final (!taken[N_MASTERS] || ((pick & eligible) == pick));

endmodule

// File: rtl/grant_stage.sv
module grant_stage #(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0,
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ready,
    input  logic [N_MASTERS-1:0] pick,
    output logic [N_MASTERS-1:0] grant,
    output logic [IDW-1:0]       owner_id
);
    localparam logic [N_MASTERS-1:0] RESET_GRANT = N_MASTERS'(1) << DEFAULT_MASTER;

    logic [IDW-1:0] grant_idx;

    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (grant[i]) grant_idx = IDW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant    <= RESET_GRANT;
            owner_id <= IDW'(DEFAULT_MASTER);
        end else if (ready) begin
            grant    <= pick;
            owner_id <= grant_idx;
        end
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot(grant));
    // R5
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ($stable(grant) && $stable(owner_id)));
    // R6
    owner_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> grant_idx != owner_id || $past(grant) == grant);

endmodule

// File: rtl/split_bus_arbiter.sv
module split_bus_arbiter #(
    parameter int N_MASTERS      = 4,
    parameter int DEFAULT_MASTER = 0,
    localparam int IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    input  logic                 ready,
    input  logic [1:0]           resp,
    input  logic [N_MASTERS-1:0] split_release,
    output logic [N_MASTERS-1:0] grant,
    output logic [IDW-1:0]       owner_id
);
    import split_arb_pkg::*;

    bus_resp_e            resp_code;
    logic [N_MASTERS-1:0] parked;
    logic [N_MASTERS-1:0] pick;

    assign resp_code = bus_resp_e'(resp);

    split_mask_ctrl #(.N_MASTERS(N_MASTERS)) u_mask (
        .clk          (clk),
        .rst          (rst),
        .resp         (resp_code),
        .ready        (ready),
        .owner_id     (owner_id),
        .split_release(split_release),
        .parked       (parked)
    );

    prio_picker #(.N_MASTERS(N_MASTERS), .DEFAULT_MASTER(DEFAULT_MASTER)) u_pick (
        .req   (req),
        .parked(parked),
        .pick  (pick)
    );

    grant_stage #(.N_MASTERS(N_MASTERS), .DEFAULT_MASTER(DEFAULT_MASTER)) u_grant (
        .clk     (clk),
        .rst     (rst),
        .ready   (ready),
        .pick    (pick),
        .grant   (grant),
        .owner_id(owner_id)
    );

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_chk
        if (i != DEFAULT_MASTER) begin : g_nd
            // R7
            parked_not_granted_chk: assert property (@(posedge clk) disable iff (rst)
                (ready && parked[i]) |=> !grant[i]);
            // R3
            grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
                (ready && !req[i]) |=> !grant[i]);
        end
    end

endmodule

// File: tb/split_bus_arbiter_bench.sv
module split_bus_arbiter_bench;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req;
    logic       ready;
    logic [1:0] resp;
    logic [3:0] split_release;
    logic [3:0] grant;
    logic [1:0] owner_id;

    always #4 clk = ~clk;   // 125 MHz

    split_bus_arbiter u_split_bus_arbiter (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .resp(resp),
        .split_release(split_release), .grant(grant), .owner_id(owner_id)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] exp_g_q[$];
    logic [1:0] exp_o_q[$];
    string      tag_q[$];

    // reference state
    logic [3:0] m_park;
    int         m_gnt;
    int         m_own;

    function automatic int ref_pick(logic [3:0] r, logic [3:0] p);
        for (int i = 0; i < N; i++) if (r[i] && !p[i]) return i;
        return 0;
    endfunction

    task automatic step(input bit r, input logic [3:0] rq, input bit rdy,
                        input logic [1:0] rs, input logic [3:0] rel, input string tag);
        logic [3:0] np;
        @(negedge clk);
        rst = r; req = rq; ready = rdy; resp = rs; split_release = rel;
        if (r) begin
            m_park = '0; m_gnt = 0; m_own = 0;
        end else begin
            np = m_park;
            for (int i = 0; i < N; i++) begin
                if (rs == 2'b11 && !rdy && m_own == i) np[i] = 1'b1;
                else if (rel[i]) np[i] = 1'b0;
            end
            if (rdy) begin
                m_own = m_gnt;
                m_gnt = ref_pick(rq, m_park);
            end
            m_park = np;
        end
        exp_g_q.push_back(4'(1) << m_gnt);
        exp_o_q.push_back(2'(m_own));
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (exp_g_q.size() > 0) begin
            logic [3:0] eg;
            logic [1:0] eo;
            string t;
            eg = exp_g_q.pop_front();
            eo = exp_o_q.pop_front();
            t  = tag_q.pop_front();
            checks++;
            if (grant !== eg || owner_id !== eo || !$onehot(grant)) begin
                errors++;
                $display("FAIL %s grant=%b exp=%b owner=%0d exp=%0d", t, grant, eg, owner_id, eo);
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; ready = 1'b0; resp = 2'b00; split_release = '0;
        // R2: reset state
        repeat (3) step(1, 4'b1110, 1, 2'b00, 4'b0000, "R2 reset");
        // R3 R4 R1: every request pattern, nothing parked
        for (int p = 0; p < 16; p++) step(0, 4'(p), 1, 2'b00, 4'b0000, "R3/R4 sweep");
        // R5: wait states hold grant and owner
        step(0, 4'b0100, 1, 2'b00, 4'b0000, "R3 setup");
        step(0, 4'b0001, 0, 2'b00, 4'b0000, "R5 hold");
        step(0, 4'b0010, 0, 2'b01, 4'b0000, "R5 hold");
        step(0, 4'b0010, 1, 2'b00, 4'b0000, "R6 owner");
        step(0, 4'b0110, 1, 2'b00, 4'b0000, "R6 owner");
        // R7: split parks master 1, grant moves to 2
        step(0, 4'b0110, 0, 2'b11, 4'b0000, "R7 split wait");
        step(0, 4'b0110, 1, 2'b11, 4'b0000, "R7 split done");
        repeat (3) step(0, 4'b0110, 1, 2'b00, 4'b0000, "R7 parked");
        // R11: release of unparked master 2
        step(0, 4'b0110, 1, 2'b00, 4'b0100, "R11 idle release");
        // R4: only parked master requests -> default
        step(0, 4'b0010, 1, 2'b00, 4'b0000, "R4 default");
        step(0, 4'b0010, 1, 2'b00, 4'b0000, "R4 default");
        // R9: release master 1
        step(0, 4'b0110, 1, 2'b00, 4'b0010, "R9 release");
        repeat (2) step(0, 4'b0110, 1, 2'b00, 4'b0000, "R9 regrant");
        // R8: split with ready high, retry/error with ready low
        step(0, 4'b0110, 1, 2'b11, 4'b0000, "R8 split ready");
        step(0, 4'b0110, 0, 2'b10, 4'b0000, "R8 retry");
        step(0, 4'b0110, 1, 2'b10, 4'b0000, "R8 retry");
        step(0, 4'b0110, 0, 2'b01, 4'b0000, "R8 error");
        repeat (2) step(0, 4'b0110, 1, 2'b00, 4'b0000, "R8 not parked");
        // R10: split and release for owner together
        step(0, 4'b0110, 0, 2'b11, 4'b0010, "R10 conflict");
        step(0, 4'b0110, 1, 2'b11, 4'b0000, "R10 conflict");
        repeat (2) step(0, 4'b0110, 1, 2'b00, 4'b0000, "R10 stays parked");
        // sweep with master 1 parked
        for (int p = 0; p < 16; p++) step(0, 4'(p), 1, 2'b00, 4'b0000, "R3/R7 parked sweep");
        // park default master 0 too
        step(0, 4'b0001, 1, 2'b00, 4'b0010, "R9 release");
        repeat (2) step(0, 4'b0001, 1, 2'b00, 4'b0000, "R3 setup");
        step(0, 4'b0001, 0, 2'b11, 4'b0000, "R7 park default");
        step(0, 4'b0011, 1, 2'b11, 4'b0000, "R7 park default");
        for (int p = 0; p < 16; p++) step(0, 4'(p), 1, 2'b00, 4'b0000, "R4 default parked sweep");
        // R2: reset clears parking
        step(1, 4'b0000, 1, 2'b00, 4'b0000, "R2 reset");
        step(0, 4'b0001, 1, 2'b00, 4'b0000, "R2 unparked");
        step(0, 4'b0011, 1, 2'b00, 4'b0000, "R2 unparked");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule